// File: doc/BRIEF.md
# Register-Programmed Clock Divider

This block derives a slower clock from its input clock. The divide ratio is set by a small bit field inside a 32-bit control word written over a memory-mapped bus. Elaboration parameters fix where the field sits, how wide it is, and how its value turns into a divisor. The divisor can be the value plus one, the raw value, two raised to the value, or a lookup in a short table. The block decodes the field, produces the divided clock, and returns the decoded divisor so software can read back the ratio in effect.

The register can be built so that each setting bit in the low half-word changes only when its partner enable bit, sixteen places higher, is set in the same write. It can also be built as read-only, keeping its reset setting. A field value with no valid divisor stops the output clock in the low state and raises an error flag. The flag clears on the next write that yields a valid value. A new ratio waits for the current output period to finish before it takes effect.

Top module: `clkdiv_regprog`

## Requirements
- R1: In plus-one encoding, the divisor is the field value plus one. Field value 0 gives divide-by-one, where the output follows the input clock.
- R2: In raw encoding, a nonzero field value is the divisor itself.
- R3: In raw encoding without the zero-bypass option, field value 0 is invalid.
- R4: In raw encoding with the zero-bypass option, field value 0 passes the input clock straight through (divide by one), and no error is raised.
- R5: In power-of-two encoding, the divisor is 2 to the power of the field value.
- R6: In table encoding, the field value is compared with the table entries in index order. The first match gives the divisor. The scan stops at the first entry whose divisor is 0, so entries after that entry never match. The default table maps 0 to 3 and 1 to 5, has its terminator at index 2, and holds an entry for value 3 at index 3 that is never reached.
- R7: In half-word-mask mode, setting bit n (n < 16) is written only when bit n+16 of the same write is 1. Otherwise bit n keeps its value.
- R8: In read-only mode, no write changes the setting or the returned divisor.
- R9: When the field value is invalid, `err_o` is 1 and, once the current output period has ended, `div_clk_o` stays low. Both return to normal on the next write that gives a valid value.
- R10: A changed divisor takes effect only after the current output period has finished. The pulse in progress is never shortened.
- R11: For a divisor N of 2 or more, the output is high for ceil(N/2) input cycles and low for floor(N/2) input cycles in each period.
- R12: `divisor_o` always shows the divisor decoded from the current field, and shows 0 while the field is invalid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Input clock to be divided |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write strobe for the control word |
| wr_data_i | input | 32 | Control word data, divisor field at FIELD_LSB |
| div_clk_o | output | 1 | Divided clock output |
| divisor_o | output | DIV_W | Decoded divisor readback, 0 when invalid |
| err_o | output | 1 | Field value is invalid |

## Verification
On every cycle, the assertions check four things:
- each high phase of the output lasts exactly half the divisor it started with, rounded up;
- a stopped divider holds its output low;
- an error always comes with a zero readback;
- a read-only or fully unenabled masked write leaves the readback unchanged.

Only the bench's sweeps can show that each encoding decodes correctly over every field value. The same holds for the table terminator cutting off later entries, the low-phase lengths, and a ratio change mid-period letting the old period finish before the new one starts.

// File: rtl/clkdiv_regprog_pkg.sv
package clkdiv_regprog_pkg;
    typedef enum logic [1:0] {
        ENC_PLUS_ONE = 2'd0,
        ENC_RAW      = 2'd1,
        ENC_POW2     = 2'd2,
        ENC_TABLE    = 2'd3
    } enc_e;
endpackage

// File: rtl/clkdiv_field_reg.sv
module clkdiv_field_reg #(
    parameter int                   FIELD_LSB     = 4,
    parameter int                   FIELD_W       = 3,
    parameter bit                   HALFWORD_MASK = 1'b0,
    parameter bit                   READ_ONLY     = 1'b0,
    parameter logic [FIELD_W-1:0]   RESET_VAL     = '0
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               wr_en_i,
    input  logic [31:0]        wr_data_i,
    output logic [FIELD_W-1:0] field_o
);
    localparam int EN_OFS = 16;

    logic [FIELD_W-1:0] field_d, field_q;

    // Next-value logic: masked or plain write, or hold.
    always_comb begin
        field_d = field_q;
        if (wr_en_i && !READ_ONLY) begin
            if (HALFWORD_MASK) begin
                for (int i = 0; i < FIELD_W; i++) begin
                    if (wr_data_i[FIELD_LSB + i + EN_OFS]) begin
                        field_d[i] = wr_data_i[FIELD_LSB + i];
                    end
                end
            end else begin
                field_d = wr_data_i[FIELD_LSB +: FIELD_W];
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) field_q <= RESET_VAL;
        else         field_q <= field_d;
    end

    assign field_o = field_q;
endmodule

// File: rtl/clkdiv_decode.sv
module clkdiv_decode
    import clkdiv_regprog_pkg::*;
#(
    parameter int                     FIELD_W     = 3,
    parameter int                     DIV_W       = 8,
    parameter enc_e                   ENC         = ENC_PLUS_ONE,
    parameter bit                     ZERO_BYPASS = 1'b0,
    parameter int                     TBL_N       = 4,
    parameter int                     TBL_EW      = 8,
    parameter logic [TBL_N*TBL_EW-1:0] TBL_VAL    = '0,
    parameter logic [TBL_N*TBL_EW-1:0] TBL_DIV    = '0
) (
    input  logic [FIELD_W-1:0] field_i,
    output logic [DIV_W-1:0]   div_o,
    output logic               ok_o
);
    logic done;

    always_comb begin
        div_o = '0;
        ok_o  = 1'b0;
        done  = 1'b0;
        unique case (ENC)
            ENC_PLUS_ONE: begin
                div_o = DIV_W'(field_i) + DIV_W'(1);
                ok_o  = 1'b1;
            end
            ENC_RAW: begin
                if (field_i != '0) begin
                    div_o = DIV_W'(field_i);
                    ok_o  = 1'b1;
                end else if (ZERO_BYPASS) begin
                    div_o = DIV_W'(1);
                    ok_o  = 1'b1;
                end
            end
            ENC_POW2: begin
                if (32'(field_i) < DIV_W) begin
                    div_o = DIV_W'(1) << field_i;
                    ok_o  = 1'b1;
                end
            end
            default: begin
                for (int i = 0; i < TBL_N; i++) begin
                    if (!done) begin
                        if (TBL_DIV[i*TBL_EW +: TBL_EW] == '0) begin
                            done = 1'b1;
                        end else if (TBL_VAL[i*TBL_EW +: TBL_EW] == TBL_EW'(field_i)) begin
                            div_o = DIV_W'(TBL_DIV[i*TBL_EW +: TBL_EW]);
                            ok_o  = 1'b1;
                            done  = 1'b1;
                        end
                    end
                end
            end
        endcase
    end
endmodule

// File: rtl/clkdiv_wavegen.sv
module clkdiv_wavegen #(
    parameter int DIV_W = 8
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [DIV_W-1:0] div_i,
    input  logic             ok_i,
    output logic             div_clk_o,
    output logic             phase_o,
    output logic [DIV_W-1:0] act_o
);
    typedef struct packed {
        logic [DIV_W-1:0] cnt;
        logic [DIV_W-1:0] act;
        logic             phase;
    } wave_st_t;

    wave_st_t st_d, st_q;
    logic     period_end;

    function automatic logic [DIV_W:0] hi_len(input logic [DIV_W-1:0] n);
        return ({1'b0, n} + (DIV_W+1)'(1)) >> 1;
    endfunction

    always_comb begin
        st_d       = st_q;
        period_end = (st_q.act == '0) || (st_q.cnt == st_q.act - DIV_W'(1));
        if (period_end) begin
            st_d.act   = ok_i ? div_i : '0;
            st_d.cnt   = '0;
            st_d.phase = (st_d.act >= DIV_W'(2));
        end else begin
            st_d.cnt   = st_q.cnt + DIV_W'(1);
            st_d.phase = ({1'b0, st_d.cnt} < hi_len(st_q.act));
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign div_clk_o = (st_q.act == DIV_W'(1)) ? clk_i : st_q.phase;
    assign phase_o   = st_q.phase;
    assign act_o     = st_q.act;
endmodule

// File: rtl/clkdiv_regprog.sv
module clkdiv_regprog
    import clkdiv_regprog_pkg::*;
#(
    parameter int                      FIELD_LSB     = 4,
    parameter int                      FIELD_W       = 3,
    parameter int                      DIV_W         = 8,
    parameter enc_e                    ENC           = ENC_PLUS_ONE,
    parameter bit                      ZERO_BYPASS   = 1'b0,
    parameter bit                      HALFWORD_MASK = 1'b0,
    parameter bit                      READ_ONLY     = 1'b0,
    parameter logic [FIELD_W-1:0]      RESET_VAL     = '0,
    parameter int                      TBL_N         = 4,
    parameter int                      TBL_EW        = 8,
    parameter logic [TBL_N*TBL_EW-1:0] TBL_VAL       = {8'd3, 8'd2, 8'd1, 8'd0},
    parameter logic [TBL_N*TBL_EW-1:0] TBL_DIV       = {8'd7, 8'd0, 8'd5, 8'd3}
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             wr_en_i,
    input  logic [31:0]      wr_data_i,
    output logic             div_clk_o,
    output logic [DIV_W-1:0] divisor_o,
    output logic             err_o
);
    logic [FIELD_W-1:0] field_w;
    logic [DIV_W-1:0]   dec_div_w;
    logic               dec_ok_w;
    logic               phase_w;
    logic [DIV_W-1:0]   act_w;

    clkdiv_field_reg #(
        .FIELD_LSB(FIELD_LSB), .FIELD_W(FIELD_W), .HALFWORD_MASK(HALFWORD_MASK),
        .READ_ONLY(READ_ONLY), .RESET_VAL(RESET_VAL)
    ) u_reg (
        .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i),
        .wr_data_i(wr_data_i), .field_o(field_w)
    );

    clkdiv_decode #(
        .FIELD_W(FIELD_W), .DIV_W(DIV_W), .ENC(ENC), .ZERO_BYPASS(ZERO_BYPASS),
        .TBL_N(TBL_N), .TBL_EW(TBL_EW), .TBL_VAL(TBL_VAL), .TBL_DIV(TBL_DIV)
    ) u_dec (
        .field_i(field_w), .div_o(dec_div_w), .ok_o(dec_ok_w)
    );

    clkdiv_wavegen #(.DIV_W(DIV_W)) u_gen (
        .clk_i(clk_i), .rst_ni(rst_ni), .div_i(dec_div_w), .ok_i(dec_ok_w),
        .div_clk_o(div_clk_o), .phase_o(phase_w), .act_o(act_w)
    );

    assign divisor_o = dec_div_w;
    assign err_o     = !dec_ok_w;
endmodule

// File: rtl/clkdiv_regprog_chk.sv
module clkdiv_regprog_chk #(
    parameter int DIV_W         = 8,
    parameter bit HALFWORD_MASK = 1'b0,
    parameter bit READ_ONLY     = 1'b0
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic             wr_en_i,
    input logic [31:0]      wr_data_i,
    input logic             div_clk_o,
    input logic [DIV_W-1:0] divisor_o,
    input logic             err_o,
    input logic             phase_i,
    input logic [DIV_W-1:0] act_i
);
    logic             prev_q;
    logic [DIV_W:0]   run_q;
    logic [DIV_W:0]   lat_q;

    // High-phase length tracked with counters instead of deep $past.
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            prev_q <= 1'b0;
            run_q  <= '0;
            lat_q  <= '0;
        end else begin
            prev_q <= phase_i;
            if (phase_i && !prev_q) begin
                run_q <= (DIV_W+1)'(1);
                lat_q <= {1'b0, act_i};
            end else if (phase_i) begin
                run_q <= run_q + (DIV_W+1)'(1);
            end
            if (!phase_i && prev_q) begin
                a_r10_full_high: assert (run_q == ((lat_q + (DIV_W+1)'(1)) >> 1))
                    else $error("R10/R11 high phase length %0d for divisor %0d", run_q, lat_q);
            end
        end
    end

    a_r9_stopped_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (act_i == '0) |-> !div_clk_o);

    a_r12_err_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
        err_o |-> (divisor_o == '0));

    generate
        if (READ_ONLY) begin : g_ro
            a_r8_ro_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
                wr_en_i |=> $stable(divisor_o));
        end
        if (HALFWORD_MASK) begin : g_mask
            a_r7_mask_ignore: assert property (@(posedge clk_i) disable iff (!rst_ni)
                (wr_en_i && wr_data_i[31:16] == 16'h0) |=> $stable(divisor_o));
        end
    endgenerate
endmodule

bind clkdiv_regprog clkdiv_regprog_chk #(
    .DIV_W(DIV_W), .HALFWORD_MASK(HALFWORD_MASK), .READ_ONLY(READ_ONLY)
) u_chk (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .wr_data_i(wr_data_i),
    .div_clk_o(div_clk_o), .divisor_o(divisor_o), .err_o(err_o),
    .phase_i(phase_w), .act_i(act_w)
);

// File: tb/clkdiv_regprog_bench.sv
`timescale 1ns/1ps
module clkdiv_regprog_bench;
    import clkdiv_regprog_pkg::*;

    localparam int NI = 6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [NI-1:0] outs;
    logic [NI-1:0] errs;
    logic [7:0]    divs [NI];
    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    clkdiv_regprog #(.ENC(ENC_PLUS_ONE)) u_clkdiv_regprog (
        .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_data_i(wr_data),
        .div_clk_o(outs[0]), .divisor_o(divs[0]), .err_o(errs[0]));
    clkdiv_regprog #(.ENC(ENC_RAW), .HALFWORD_MASK(1'b1)) u_raw (
        .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_data_i(wr_data),
        .div_clk_o(outs[1]), .divisor_o(divs[1]), .err_o(errs[1]));
    clkdiv_regprog #(.ENC(ENC_RAW), .ZERO_BYPASS(1'b1)) u_rawz (
        .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_data_i(wr_data),
        .div_clk_o(outs[2]), .divisor_o(divs[2]), .err_o(errs[2]));
    clkdiv_regprog #(.ENC(ENC_POW2)) u_pow (
        .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_data_i(wr_data),
        .div_clk_o(outs[3]), .divisor_o(divs[3]), .err_o(errs[3]));
    clkdiv_regprog #(.ENC(ENC_TABLE)) u_tbl (
        .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_data_i(wr_data),
        .div_clk_o(outs[4]), .divisor_o(divs[4]), .err_o(errs[4]));
    clkdiv_regprog #(.ENC(ENC_PLUS_ONE), .READ_ONLY(1'b1), .RESET_VAL(3'd3)) u_ro (
        .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_data_i(wr_data),
        .div_clk_o(outs[5]), .divisor_o(divs[5]), .err_o(errs[5]));

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr_raw(input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1;
        wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // Field at bits 6:4, enables at 22:20 for the masked instance.
    task automatic wr_field(input int v);
        wr_raw((32'(v) << 4) | (32'h7 << 20));
    endtask

    task automatic settle();
        repeat (100) @(negedge clk);
    endtask

    task automatic measure(input int idx, output int hi, output int lo);
        bit prev;
        int guard;
        hi = 0; lo = 0; guard = 0;
        @(negedge clk); prev = outs[idx];
        forever begin
            @(negedge clk);
            guard++;
            if (outs[idx] && !prev) break;
            prev = outs[idx];
            if (guard > 400) return;
        end
        while (outs[idx] && guard < 800) begin hi++; guard++; @(negedge clk); end
        while (!outs[idx] && guard < 800) begin lo++; guard++; @(negedge clk); end
    endtask

    task automatic check_div(input int idx, input int n, input string req);
        int hi, lo;
        measure(idx, hi, lo);
        chk(hi == (n + 1) / 2, {req, " high phase"}, hi, (n + 1) / 2);
        chk(lo == n / 2, {req, " low phase"}, lo, n / 2);
    endtask

    task automatic check_bypass(input int idx, input string req);
        @(posedge clk); #1;
        chk(outs[idx] == 1'b1, {req, " bypass high"}, outs[idx], 1);
        @(negedge clk); #1;
        chk(outs[idx] == 1'b0, {req, " bypass low"}, outs[idx], 0);
    endtask

    task automatic check_held_low(input int idx, input string req);
        int highs = 0;
        for (int k = 0; k < 40; k++) begin
            @(negedge clk);
            if (outs[idx]) highs++;
        end
        chk(highs == 0, {req, " output held low"}, highs, 0);
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(outs == '0, "reset output low", int'(outs), 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(divs[0] == 1, "R12 reset readback plus-one", divs[0], 1);
        chk(divs[5] == 4, "R8 reset readback read-only", divs[5], 4);
        chk(errs[1] == 1'b1, "R3 reset raw zero error", errs[1], 1);

        // R1, R11: plus-one sweep; R5 power-of-two sweep alongside
        for (int v = 0; v < 8; v++) begin
            wr_field(v);
            settle();
            chk(divs[0] == v + 1, "R1 readback", divs[0], v + 1);
            if (v == 0) check_bypass(0, "R1");
            else        check_div(0, v + 1, "R1 R11");
            if (v < 6) begin
                chk(divs[3] == (1 << v), "R5 readback", divs[3], 1 << v);
                if (v == 0) check_bypass(3, "R5");
                else        check_div(3, 1 << v, "R5");
            end
            // R2: raw nonzero values
            if (v > 0) begin
                chk(divs[1] == v, "R2 readback", divs[1], v);
                if (v == 1) check_bypass(1, "R2");
                else        check_div(1, v, "R2");
            end
            // R8: read-only ignores every write
            chk(divs[5] == 4, "R8 read-only readback", divs[5], 4);
            // R6: table sweep
            if (v == 0) begin
                chk(divs[4] == 3 && !errs[4], "R6 table value 0", divs[4], 3);
                check_div(4, 3, "R6");
            end else if (v == 1) begin
                chk(divs[4] == 5 && !errs[4], "R6 table value 1", divs[4], 5);
                check_div(4, 5, "R6");
            end else begin
                chk(errs[4] == 1'b1, "R6 R9 table miss error", errs[4], 1);
                chk(divs[4] == 0, "R6 R12 table miss readback", divs[4], 0);
            end
        end
        check_div(5, 4, "R8 read-only period");
        check_held_low(4, "R9 table");

        // R3, R4, R9: zero in raw encodings
        wr_field(0);
        settle();
        chk(errs[1] == 1'b1, "R3 raw zero error", errs[1], 1);
        chk(divs[1] == 0, "R3 R12 raw zero readback", divs[1], 0);
        check_held_low(1, "R3 R9");
        chk(errs[2] == 1'b0, "R4 zero-bypass no error", errs[2], 0);
        chk(divs[2] == 1, "R4 zero-bypass readback", divs[2], 1);
        check_bypass(2, "R4");
        wr_field(3);
        chk(errs[1] == 1'b0, "R9 error cleared", errs[1], 1'b0);
        settle();
        check_div(1, 3, "R9 recovered");

        // R7: half-word mask on the raw instance (field now 3)
        wr_raw((32'h5 << 4) | (32'h2 << 20));
        chk(divs[1] == 1, "R7 single enabled bit", divs[1], 1);
        wr_raw(32'h7 << 4);
        chk(divs[1] == 1, "R7 no enable bits", divs[1], 1);
        wr_raw((32'h6 << 4) | (32'h4 << 20));
        chk(divs[1] == 5, "R7 upper bit enabled", divs[1], 5);

        // R10: change mid-period from 8 to 2
        wr_field(7);
        settle();
        begin
            bit prev;
            int hi = 1, lo = 0, hi2 = 0, guard = 0;
            @(negedge clk); prev = outs[0];
            forever begin
                @(negedge clk);
                if (outs[0] && !prev) break;
                prev = outs[0];
            end
            wr_en = 1'b1;
            wr_data = 32'h1 << 4;
            @(negedge clk);
            wr_en = 1'b0;
            while (outs[0] && guard < 100) begin hi++; guard++; @(negedge clk); end
            while (!outs[0] && guard < 100) begin lo++; guard++; @(negedge clk); end
            while (outs[0] && guard < 100) begin hi2++; guard++; @(negedge clk); end
            chk(hi == 4, "R10 old high phase kept", hi, 4);
            chk(lo == 4, "R10 old low phase kept", lo, 4);
            chk(hi2 == 1, "R10 new divisor after period", hi2, 1);
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule